// File: doc/BRIEF.md
# Multi-PHY Cell Transmit Slave Interface

This block sits on the PHY side of a shared cell transmit bus that several PHY devices share. A single master drives a 5-bit device address, an active-low write enable, 16-bit data words with a parity bit, and a start-of-cell marker. The block decides from the address and enable whether the master has picked it as the write target. It then gathers the words of each fixed 27-word cell (54 bytes) into a small cell FIFO. The line side drains that FIFO one word at a time.

Three error conditions are detected while cells arrive:
- a word parity error;
- a break in cell alignment, such as a cell cut short by a new start-of-cell marker, or a word arriving outside any cell;
- an attempt to start a cell while every FIFO slot is taken.

Each condition sets a sticky status bit that a register read returns and clears in the same access. Each status bit has its own enable. An interrupt line reports any enabled status. Two control bits in the same register set the policy for cells that carry a parity error and hold the FIFO empty.

Top module: `cell_tx_slave`

## Requirements
- R1: In any cycle where `bus_en_n` is 1, the block becomes selected if `bus_addr` equals the `MY_ADDR` parameter and deselected otherwise. A word is accepted only in a cycle where `bus_en_n` is 0 and the block is selected.
- R2: In cycles where `bus_en_n` is 0, the selection does not change, whatever appears on `bus_addr`. Polling this block's address while another device is selected accepts no data.
- R3: Address 5'h1F never selects the block. Seeing it while `bus_en_n` is 1 leaves the block deselected.
- R4: A cell is 27 accepted words, and the first word has `bus_soc`=1. A stored cell appears at the read port, word 0 first, only after its word 26 has been accepted. `out_valid`=1 marks a word on `out_word`, and `out_pop`=1 with `out_valid`=1 advances to the next word.
- R5: Parity is odd over `bus_data` and `bus_par`. An accepted word whose 17 bits XOR to 0 sets status bit 2.
- R6: When control bit 6 is 1, a cell with a parity error in any of its words is not stored. When bit 6 is 0, the cell is stored anyway.
- R7: An accepted `bus_soc`=1 word arriving while a cell is in progress sets status bit 0, drops the partial cell and starts a new cell at that word. An accepted `bus_soc`=0 word outside any cell sets status bit 0 and is dropped.
- R8: An accepted `bus_soc`=1 word arriving while all `CELL_SLOTS` slots hold stored cells sets status bit 1, and the whole of that cell is dropped.
- R9: `cell_room` is 1 exactly when the stored cells plus the cell being assembled number fewer than `CELL_SLOTS`. It lags the slot count by one cycle.
- R10: A cycle with `reg_rd`=1 loads `reg_rdata` with {control bits 7..3, status bits 2..0} on the next edge. The same edge clears the status bits, except a bit whose condition occurs in that cycle. A cycle with `reg_wr`=1 loads control bits 7..3 from `reg_wdata[7:3]`.
- R11: `irq` is registered. It is 1 one cycle after any status bit n (n = 0..2) is 1 while enable bit n+3 is 1, and 0 otherwise.
- R12: While control bit 7 is 1, the FIFO is held empty, any partial cell is dropped, no word is accepted and `out_valid` is 0.
- R13: After reset:
  - `out_valid` = 0
  - `irq` = 0
  - `cell_room` = 1
  - all register bits = 0
  - the block is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Device address driven by the master |
| bus_en_n | input | 1 | Active-low write enable |
| bus_data | input | DATA_W | Cell data word |
| bus_par | input | 1 | Odd parity bit for `bus_data` |
| bus_soc | input | 1 | Marks word 0 of a cell |
| cell_room | output | 1 | Room for one more whole cell |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Enabled-status interrupt |
| out_pop | input | 1 | Line side takes the current word |
| out_valid | output | 1 | A stored word is presented |
| out_word | output | DATA_W | Stored word, in cell order |

## Verification
The bench builds the block with `MY_ADDR` = 2 and `CELL_SLOTS` = 2, keeping 27-word cells and 16-bit data. Two slots mean the third back-to-back cell, sent with the drain stopped, hits the overrun path, and `cell_room` falls after only two cells. Choosing a non-zero own address lets the bench switch to addresses 0, 7 and 1Fh around it. This covers polling during a transfer, deselection by another device and the never-selecting null address.

// File: rtl/cell_tx_pkg.sv
package cell_tx_pkg;
  // Register bit positions: status[2:0], enables[5:3] (enable n+3 pairs with status n)
  localparam int ST_ALIGN    = 0;
  localparam int ST_OVR      = 1;
  localparam int ST_PAR      = 2;
  localparam int EN_LSB      = 3;
  localparam int CTL_DISCARD = 6;
  localparam int CTL_FLUSH   = 7;

  // Packed so that the bit order matches status[2:0]
  typedef struct packed {
    logic perr;
    logic ovr;
    logic align;
  } evt_t;
endpackage

// File: rtl/cell_tx_select.sv
module cell_tx_select #(
  parameter int                ADDR_W  = 5,
  parameter logic [ADDR_W-1:0] MY_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_n,
  output logic              selected
);
  localparam logic [ADDR_W-1:0] NULL_ADDR = '1;

  // Selection is only re-evaluated in cycles where the write enable is high
  always_ff @(posedge clk) begin
    if (rst)
      selected <= 1'b0;
    else if (en_n)
      selected <= (addr == MY_ADDR) && (addr != NULL_ADDR);
  end
endmodule

// File: rtl/cell_tx_ram.sv
module cell_tx_ram #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 54,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Simple dual-port, registered read, no reset: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cell_tx_csr.sv
module cell_tx_csr
  import cell_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  input  evt_t       evt,
  output logic [7:0] rdata,
  output logic [2:0] en,
  output logic       discard,
  output logic       flush,
  output logic [2:0] status,
  output logic       irq
);
  logic [7:3] ctl_q;
  logic [2:0] st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      st_q  <= '0;
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (wr)
        ctl_q <= wdata[7:3];
      // A new event wins over the clear caused by a read in the same cycle
      st_q <= (rd ? 3'b000 : st_q) | evt;
      if (rd)
        rdata <= {ctl_q, st_q};
      irq <= |(st_q & ctl_q[EN_LSB+2:EN_LSB]);
    end
  end

  assign en      = ctl_q[EN_LSB+2:EN_LSB];
  assign discard = ctl_q[CTL_DISCARD];
  assign flush   = ctl_q[CTL_FLUSH];
  assign status  = st_q;
endmodule

// File: rtl/cell_tx_asm.sv
module cell_tx_asm
  import cell_tx_pkg::*;
#(
  parameter int DW    = 16,
  parameter int WORDS = 27,
  parameter int CW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          take,
  input  logic [DW-1:0] data,
  input  logic          par,
  input  logic          soc,
  input  logic          discard,
  input  logic          full,
  output logic          wr_en,
  output logic [CW-1:0] wr_idx,
  output logic          commit,
  output logic          holding,
  output evt_t          evt
);
  localparam logic [CW-1:0] LAST = CW'(WORDS - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          act_q, act_n;   // inside a cell
  logic          drop_q, drop_n; // cell has no slot, words are counted only
  logic          bad_q, bad_n;   // cell carried a parity error
  logic          perr;

  assign perr = ~(^{data, par});

  always_comb begin
    cnt_n  = cnt_q;
    act_n  = act_q;
    drop_n = drop_q;
    bad_n  = bad_q;
    wr_en  = 1'b0;
    wr_idx = cnt_q;
    commit = 1'b0;
    evt    = '0;
    if (take) begin
      evt.perr = perr;
      if (soc) begin
        evt.align = act_q;        // runt: previous cell cut short
        act_n  = 1'b1;
        cnt_n  = CW'(1);
        bad_n  = perr;
        if (full) begin
          evt.ovr = 1'b1;
          drop_n  = 1'b1;
        end else begin
          drop_n = 1'b0;
          wr_en  = 1'b1;
          wr_idx = '0;
        end
      end else if (!act_q) begin
        evt.align = 1'b1;         // stray word outside any cell
      end else begin
        wr_en = !drop_q;
        bad_n = bad_q | perr;
        if (cnt_q == LAST) begin
          act_n  = 1'b0;
          cnt_n  = '0;
          commit = !drop_q && !(bad_n && discard);
        end else begin
          cnt_n = cnt_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt_q  <= '0;
      act_q  <= 1'b0;
      drop_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      act_q  <= act_n;
      drop_q <= drop_n;
      bad_q  <= bad_n;
    end
  end

  assign holding = act_q && !drop_q;
endmodule

// File: rtl/cell_tx_slave.sv
module cell_tx_slave
  import cell_tx_pkg::*;
#(
  parameter int                ADDR_W     = 5,
  parameter logic [ADDR_W-1:0] MY_ADDR    = '0,
  parameter int                DATA_W     = 16,
  parameter int                CELL_WORDS = 27,
  parameter int                CELL_SLOTS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_en_n,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_par,
  input  logic              bus_soc,
  output logic              cell_room,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  input  logic              out_pop,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_word
);
  localparam int DEPTH = CELL_WORDS * CELL_SLOTS;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(CELL_WORDS);
  localparam int SW    = (CELL_SLOTS > 1) ? $clog2(CELL_SLOTS) : 1;
  localparam int UW    = $clog2(CELL_SLOTS + 1);
  localparam logic [CW-1:0] LAST_WORD = CW'(CELL_WORDS - 1);

  logic          sel;
  logic          take;
  logic [2:0]    ctrl_en;
  logic          ctrl_disc;
  logic          ctrl_frst;
  logic [2:0]    status;
  evt_t          evt;
  logic          wr_en;
  logic [CW-1:0] wr_idx;
  logic          commit;
  logic          holding;
  logic [AW-1:0] waddr;
  logic [AW-1:0] hptr_q, hptr_nx;
  logic [CW-1:0] hword_q;
  logic [SW-1:0] wslot_q;
  logic [UW-1:0] used_q;
  logic          full;
  logic          pop;
  logic          release_w;
  logic          room_q;

  cell_tx_select #(.ADDR_W(ADDR_W), .MY_ADDR(MY_ADDR)) u_sel (
    .clk(clk), .rst(rst), .addr(bus_addr), .en_n(bus_en_n), .selected(sel)
  );

  cell_tx_csr u_csr (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .wdata(reg_wdata),
    .evt(evt), .rdata(reg_rdata), .en(ctrl_en), .discard(ctrl_disc),
    .flush(ctrl_frst), .status(status), .irq(irq)
  );

  assign take = sel && !bus_en_n && !ctrl_frst;
  assign full = (used_q == UW'(CELL_SLOTS));

  cell_tx_asm #(.DW(DATA_W), .WORDS(CELL_WORDS), .CW(CW)) u_asm (
    .clk(clk), .rst(rst), .flush(ctrl_frst), .take(take),
    .data(bus_data), .par(bus_par), .soc(bus_soc), .discard(ctrl_disc),
    .full(full), .wr_en(wr_en), .wr_idx(wr_idx), .commit(commit),
    .holding(holding), .evt(evt)
  );

  assign waddr = AW'(wslot_q) * AW'(CELL_WORDS) + AW'(wr_idx);

  // Read side: word pointer runs across contiguous slots
  assign out_valid = (used_q != '0);
  assign pop       = out_pop && out_valid;
  assign release_w = pop && (hword_q == LAST_WORD);
  assign hptr_nx   = !pop ? hptr_q :
                     (hptr_q == AW'(DEPTH - 1)) ? '0 : hptr_q + AW'(1);

  cell_tx_ram #(.WIDTH(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(wr_en), .waddr(waddr), .wdata(bus_data),
    .raddr(hptr_nx), .rdata(out_word)
  );

  always_ff @(posedge clk) begin
    if (rst || ctrl_frst) begin
      used_q  <= '0;
      wslot_q <= '0;
      hptr_q  <= '0;
      hword_q <= '0;
      room_q  <= 1'b1;
    end else begin
      used_q <= used_q + UW'(commit) - UW'(release_w);
      if (commit)
        wslot_q <= (wslot_q == SW'(CELL_SLOTS - 1)) ? '0 : wslot_q + SW'(1);
      hptr_q <= hptr_nx;
      if (pop)
        hword_q <= release_w ? '0 : hword_q + CW'(1);
      room_q <= ({1'b0, used_q} + (UW+1)'(holding)) < (UW+1)'(CELL_SLOTS);
    end
  end

  assign cell_room = room_q;
endmodule

// File: rtl/cell_tx_slave_chk.sv
module cell_tx_slave_chk #(
  parameter int                ADDR_W     = 5,
  parameter logic [ADDR_W-1:0] MY_ADDR    = '0,
  parameter int                CELL_SLOTS = 2,
  parameter int                UW         = $clog2(CELL_SLOTS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_en_n,
  input logic              selected,
  input logic              irq,
  input logic [2:0]        en_bits,
  input logic              fifo_rst,
  input logic              out_valid,
  input logic [2:0]        status,
  input logic [UW-1:0]     used,
  input logic              reg_rd,
  input logic [7:0]        reg_rdata
);
  localparam logic [ADDR_W-1:0] NULL_ADDR = '1;

  p_select_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_en_n && bus_addr == MY_ADDR && MY_ADDR != NULL_ADDR) |=> selected);

  p_sel_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_en_n |=> $stable(selected));

  p_never_null_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_en_n && bus_addr == NULL_ADDR) |=> !selected);

  p_overrun_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(status[1]) |-> ($past(used) == UW'(CELL_SLOTS)));

  p_rdata_r10: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rd) |-> (reg_rdata[2:0] == $past(status)));

  p_irq_masked_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(en_bits) == 3'b000) |-> !irq);

  p_flush_r12: assert property (@(posedge clk) disable iff (rst)
    $past(fifo_rst) |-> !out_valid);
endmodule

bind cell_tx_slave cell_tx_slave_chk #(
  .ADDR_W(ADDR_W), .MY_ADDR(MY_ADDR), .CELL_SLOTS(CELL_SLOTS)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_en_n(bus_en_n),
  .selected(sel), .irq(irq), .en_bits(ctrl_en), .fifo_rst(ctrl_frst),
  .out_valid(out_valid), .status(status), .used(used_q),
  .reg_rd(reg_rd), .reg_rdata(reg_rdata)
);

// File: tb/sim_cell_tx_slave.sv
`timescale 1ns/1ps
module sim_cell_tx_slave;
  localparam logic [4:0] MINE = 5'h02;
  localparam int WORDS = 27;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = 5'h00;
  logic        bus_en_n = 1'b1;
  logic [15:0] bus_data = '0;
  logic        bus_par = 1'b0;
  logic        bus_soc = 1'b0;
  logic        cell_room;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq;
  logic        out_pop = 1'b0;
  logic        out_valid;
  logic [15:0] out_word;

  int checks = 0;
  int fails  = 0;
  bit drain  = 1'b1;
  bit done   = 1'b0;
  logic [4:0] cur_sel = 5'h00;
  logic [15:0] exp_q[$];

  always #2.5 clk = ~clk;

  cell_tx_slave #(.MY_ADDR(MINE), .CELL_SLOTS(2)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_en_n(bus_en_n),
    .bus_data(bus_data), .bus_par(bus_par), .bus_soc(bus_soc),
    .cell_room(cell_room), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .out_pop(out_pop), .out_valid(out_valid), .out_word(out_word)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel_dev(input logic [4:0] a);
    bus_en_n = 1'b1;
    bus_addr = a;
    cur_sel  = a;
    @(negedge clk);
  endtask

  // Sends n words; poll_a is on the address bus while words are written
  task automatic send_cell(input logic [15:0] base, input int n, input int bad_at,
                           input bit first_soc, input logic [4:0] poll_a,
                           input bit expect_store);
    if (expect_store)
      for (int w = 0; w < n; w++) exp_q.push_back(base + 16'(w));
    for (int w = 0; w < n; w++) begin
      bus_en_n = 1'b0;
      bus_addr = poll_a;
      bus_data = base + 16'(w);
      bus_par  = ~(^(base + 16'(w))) ^ (w == bad_at);
      bus_soc  = first_soc && (w == 0);
      @(negedge clk);
    end
    bus_en_n = 1'b1;
    bus_addr = cur_sel;
    bus_soc  = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] v);
    reg_wr = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_check(input string tag, input logic [7:0] exp);
    reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    check(tag, int'(reg_rdata), int'(exp));
  endtask

  // Monitor: pops the scoreboard as the block presents words (R4)
  initial begin
    forever begin
      @(negedge clk);
      if (drain && out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R4: actual %0h expected none", out_word);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          if (out_word !== e) begin
            fails++;
            $display("FAIL R4: actual %0h expected %0h", out_word, e);
          end
        end
        out_pop = 1'b1;
      end else begin
        out_pop = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R13 reset state
    check("R13 out_valid", out_valid, 0);
    check("R13 irq", irq, 0);
    check("R13 cell_room", cell_room, 1);
    reg_check("R13 register", 8'h00);
    reg_write(8'h38);

    // R2 / R1: poll own address while another device is selected
    sel_dev(5'h07);
    send_cell(16'h1100, WORDS, -1, 1, MINE, 0);
    idle(40);
    check("R2 poll stored nothing", out_valid, 0);
    reg_check("R1 no word accepted", 8'h38);

    // R4 / R2: select, write a cell while other addresses are polled
    sel_dev(MINE);
    send_cell(16'h1000, WORDS, -1, 1, 5'h00, 1);
    idle(40);
    check("R4 cell drained", exp_q.size(), 0);
    reg_check("R4 no errors", 8'h38);

    // R3: null address deselects and never selects
    sel_dev(5'h1F);
    send_cell(16'h2000, WORDS, -1, 1, MINE, 0);
    idle(40);
    check("R3 nothing stored", out_valid, 0);
    reg_check("R3 no events", 8'h38);

    // R5 / R11 / R10: parity error with discard off
    sel_dev(MINE);
    send_cell(16'h3000, WORDS, 5, 1, 5'h1F, 1);
    idle(3);
    check("R11 irq set", irq, 1);
    idle(40);
    reg_check("R5 parity status", 8'h3C);
    reg_check("R10 cleared by read", 8'h38);
    idle(2);
    check("R11 irq cleared", irq, 0);

    // R6: discard on drops a bad cell
    reg_write(8'h78);
    send_cell(16'h4000, WORDS, 26, 1, MINE, 0);
    idle(40);
    check("R6 bad cell dropped", out_valid, 0);
    reg_check("R6 status", 8'h7C);

    // R7: runt followed by a full cell
    send_cell(16'h5000, 10, -1, 1, MINE, 0);
    send_cell(16'h6000, WORDS, -1, 1, MINE, 1);
    idle(40);
    reg_check("R7 runt status", 8'h79);
    check("R7 only full cell", exp_q.size(), 0);
    send_cell(16'h7000, 1, -1, 0, MINE, 0);
    idle(5);
    reg_check("R7 stray word", 8'h79);
    check("R7 stray dropped", out_valid, 0);

    // R8 / R9: overrun with drain stopped
    drain = 1'b0;
    idle(2);
    send_cell(16'h8000, WORDS, -1, 1, MINE, 1);
    send_cell(16'h9000, WORDS, -1, 1, MINE, 1);
    idle(3);
    check("R9 no room", cell_room, 0);
    send_cell(16'hA000, WORDS, -1, 1, MINE, 0);
    idle(3);
    reg_check("R8 overrun status", 8'h7A);
    check("R8 cells held", out_valid, 1);
    drain = 1'b1;
    idle(80);
    check("R9 room back", cell_room, 1);
    check("R8 third cell dropped", exp_q.size(), 0);

    // R11 masked, R5 again
    reg_write(8'h00);
    send_cell(16'hB000, WORDS, 0, 1, MINE, 1);
    idle(40);
    check("R11 masked irq", irq, 0);
    reg_check("R5 masked status", 8'h04);

    // R12: FIFO hold-empty control
    drain = 1'b0;
    idle(2);
    send_cell(16'hC000, WORDS, -1, 1, MINE, 0);
    idle(3);
    check("R12 cell present", out_valid, 1);
    reg_write(8'h80);
    idle(2);
    check("R12 emptied", out_valid, 0);
    check("R12 room", cell_room, 1);
    send_cell(16'hD000, 5, -1, 1, MINE, 0);
    reg_write(8'h00);
    idle(2);
    check("R12 nothing accepted", out_valid, 0);
    drain = 1'b1;
    send_cell(16'hE000, WORDS, -1, 1, MINE, 1);
    idle(40);
    check("R12 resumes", exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule